// File: doc/BRIEF.md
# Register-Pair Immediate Add/Subtract Unit

This unit performs a 16-bit add or subtract of a small unsigned constant on one of four register pairs at the top of a 32-entry byte register file. The instruction word carries the operation, the pair select and a 6-bit immediate. The immediate is split across two fields of the word. The unit reads the selected pair as a little-endian 16-bit value and computes the result. It then writes the result back to the same pair, together with a new status byte.

A launch takes two cycles. In the read phase the unit presents the low register index of the pair, and the surrounding register file returns both bytes combinationally. In the write phase the unit drives the result bytes and the updated status byte with write strobes. The status byte keeps its three upper bits. The carry, zero, negative, overflow and sign bits are rebuilt from bit 15 of the original and result words and from the zero test of the result.

Top module: `pair_imm_adder`

## Requirements
- R1: After reset the unit is idle: `busy`, `regWrEn` and `flagsWrEn` are low.
- R2: A `start` sampled high while idle is followed by exactly one read cycle with `busy` high, and then by exactly one write cycle with `regWrEn`, `flagsWrEn` and `busy` high. After that the unit is idle again.
- R3: The low register index of the pair is 24 + 2 × instruction bits [5:4]. The high byte lives at that index + 1. The write index equals the read index.
- R4: The immediate is zero-extended from {instruction bits [7:6], instruction bits [3:0]}, with bits [7:6] supplying the top two bits.
- R5: Instruction bit 8 selects the operation: 0 adds and 1 subtracts. The result is taken modulo 2^16. The low byte goes to the even register and the high byte to the odd one.
- R6: For add, carry (status bit 0) is set when the original bit 15 is 1 and the result bit 15 is 0. Overflow (status bit 3) is set when the original bit 15 is 0 and the result bit 15 is 1.
- R7: For subtract, carry (bit 0) is set when the original bit 15 is 0 and the result bit 15 is 1. Overflow (bit 3) is set when the original bit 15 is 1 and the result bit 15 is 0.
- R8: Zero (bit 1) is set when the whole 16-bit result is zero. Negative (bit 2) equals result bit 15.
- R9: Sign (bit 4) equals negative xor overflow.
- R10: Status bits 5, 6 and 7 of `flagsOut` equal those of `flagsIn` as sampled in the read cycle.
- R11: A `start` while `busy` is high is ignored. Such a start does not alter the operation in flight, and it produces no extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| instr | input | 16 | Instruction word, captured with the launch |
| flagsIn | input | 8 | Current status byte |
| regRdLo | input | 8 | Register file byte at `regRdIdx` |
| regRdHi | input | 8 | Register file byte at `regRdIdx` + 1 |
| regRdIdx | output | 5 | Low register index of the selected pair |
| regWrEn | output | 1 | Register pair write strobe |
| regWrIdx | output | 5 | Low register index to write |
| regWrLo | output | 8 | Result low byte |
| regWrHi | output | 8 | Result high byte |
| flagsWrEn | output | 1 | Status byte write strobe |
| flagsOut | output | 8 | Updated status byte |
| busy | output | 1 | Operation in progress |

## Verification
The add path is driven with values that wrap from 0xFFFF to zero and with values that cross from 0x7FFF into negative. This separates the carry rule from the overflow rule, and both from the zero test. The subtract path is driven with a borrow out of zero, with a signed wrap out of 0x8000 and with an exact cancellation to zero. These three cases tell the subtract rules apart from the add rules. Each of the four pairs is used, and the immediates are chosen so that only the high field or only the low field is non-zero, which exposes a swapped or misplaced field. Preloaded status bytes with the lower five bits set show that stale flags are cleared, and different upper-bit patterns show that those bits are carried over.

// File: rtl/pair_imm_pkg.sv
package pair_imm_pkg;

  // status byte bit positions
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;
  localparam int KEEP_LO = FLAG_H;
  localparam int KEEP_W  = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadInstr;
    logic captureOperand;
    logic writeBack;
  } ctrlStrobes_t;

endpackage

// File: rtl/pair_imm_ctrl.sv
module pair_imm_ctrl
  import pair_imm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (start) phaseNext = PH_READ;
      PH_READ:  phaseNext = PH_WRITE;
      PH_WRITE: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobes.loadInstr      = (phase == PH_IDLE) && start;
    strobes.captureOperand = (phase == PH_READ);
    strobes.writeBack      = (phase == PH_WRITE);
    busy                   = (phase != PH_IDLE);
  end

  // R2: a read cycle is always followed by the write cycle
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureOperand |=> strobes.writeBack);

  // R2: the write strobe lasts a single cycle and returns to idle
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |=> !busy);

  // R11: a launch only ever enters from idle
  a_r11_launch_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadInstr |=> strobes.captureOperand);

  a_r2_phase_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadInstr, strobes.captureOperand, strobes.writeBack}));

endmodule

// File: rtl/pair_imm_dp.sv
module pair_imm_dp
  import pair_imm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 5,
  parameter int INSTR_W   = 16,
  parameter int IMM_W     = 6,
  parameter int PAIR_BASE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [INSTR_W-1:0] instr,
  input  logic [BYTE_W-1:0]  flagsIn,
  input  logic [BYTE_W-1:0]  rdLo,
  input  logic [BYTE_W-1:0]  rdHi,
  output logic [IDX_W-1:0]   rdIdx,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [BYTE_W-1:0]  wrLo,
  output logic [BYTE_W-1:0]  wrHi,
  output logic [BYTE_W-1:0]  flagsOut
);

  localparam int WORD_W   = 2 * BYTE_W;
  localparam int MSB      = WORD_W - 1;
  localparam int IMM_LO_W = 4;
  localparam int IMM_HI_W = IMM_W - IMM_LO_W;
  localparam int SEL_LSB  = IMM_LO_W;
  localparam int IMMH_LSB = SEL_LSB + 2;
  localparam int OP_BIT   = IMMH_LSB + IMM_HI_W;

  logic [INSTR_W-1:0] instrReg;
  logic [WORD_W-1:0]  operandReg;
  logic [KEEP_W-1:0]  keepReg;
  logic [IDX_W-1:0]   wrIdxReg;

  logic [1:0]         pairSel;
  logic [IMM_W-1:0]   immVal;
  logic               isSub;
  logic [WORD_W-1:0]  resultWord;
  logic               origTop;
  logic               resTop;
  logic               carryBit;
  logic               ovfBit;
  logic               zeroBit;

  // field decode from the captured instruction
  assign pairSel = instrReg[SEL_LSB +: 2];
  assign immVal  = {instrReg[IMMH_LSB +: IMM_HI_W], instrReg[0 +: IMM_LO_W]};
  assign isSub   = instrReg[OP_BIT];
  assign rdIdx   = IDX_W'(PAIR_BASE + 2 * int'(pairSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrReg <= '0;
    end else if (strobes.loadInstr) begin
      instrReg <= instr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      operandReg <= '0;
      keepReg    <= '0;
      wrIdxReg   <= '0;
    end else if (strobes.captureOperand) begin
      operandReg <= {rdHi, rdLo};
      keepReg    <= flagsIn[KEEP_LO +: KEEP_W];
      wrIdxReg   <= rdIdx;
    end
  end

  always_comb begin
    if (isSub) resultWord = operandReg - WORD_W'(immVal);
    else       resultWord = operandReg + WORD_W'(immVal);
  end

  assign origTop = operandReg[MSB];
  assign resTop  = resultWord[MSB];
  assign zeroBit = (resultWord == '0);

  always_comb begin
    if (isSub) begin
      carryBit = resTop & ~origTop;
      ovfBit   = origTop & ~resTop;
    end else begin
      carryBit = origTop & ~resTop;
      ovfBit   = resTop & ~origTop;
    end
  end

  always_comb begin
    flagsOut                      = '0;
    flagsOut[FLAG_C]              = carryBit;
    flagsOut[FLAG_Z]              = zeroBit;
    flagsOut[FLAG_N]              = resTop;
    flagsOut[FLAG_V]              = ovfBit;
    flagsOut[FLAG_S]              = resTop ^ ovfBit;
    flagsOut[KEEP_LO +: KEEP_W]   = keepReg;
  end

  assign wrIdx = wrIdxReg;
  assign wrLo  = resultWord[0 +: BYTE_W];
  assign wrHi  = resultWord[BYTE_W +: BYTE_W];

  // R3: written pair is the pair read one cycle earlier
  a_r3_write_idx: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |-> wrIdx == $past(rdIdx));

  // R5: an add moves the pair value by exactly the immediate
  a_r5_add_delta: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeBack && !isSub) |->
      (({wrHi, wrLo} - $past({rdHi, rdLo})) == WORD_W'(immVal)));

  // R5: a subtract moves the pair value down by exactly the immediate
  a_r5_sub_delta: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeBack && isSub) |->
      (($past({rdHi, rdLo}) - {wrHi, wrLo}) == WORD_W'(immVal)));

  // R8: zero flag agrees with the written bytes
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |-> (flagsOut[FLAG_Z] == ({wrHi, wrLo} == '0)));

  // R10: upper status bits come from the read-cycle input
  a_r10_keep_upper: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |-> flagsOut[KEEP_LO +: KEEP_W] == $past(flagsIn[KEEP_LO +: KEEP_W]));

endmodule

// File: rtl/pair_imm_adder.sv
module pair_imm_adder
  import pair_imm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 5,
  parameter int INSTR_W   = 16,
  parameter int IMM_W     = 6,
  parameter int PAIR_BASE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [BYTE_W-1:0]  flagsIn,
  input  logic [BYTE_W-1:0]  regRdLo,
  input  logic [BYTE_W-1:0]  regRdHi,
  output logic [IDX_W-1:0]   regRdIdx,
  output logic               regWrEn,
  output logic [IDX_W-1:0]   regWrIdx,
  output logic [BYTE_W-1:0]  regWrLo,
  output logic [BYTE_W-1:0]  regWrHi,
  output logic               flagsWrEn,
  output logic [BYTE_W-1:0]  flagsOut,
  output logic               busy
);

  ctrlStrobes_t strobes;

  pair_imm_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy)
  );

  pair_imm_dp #(
    .BYTE_W    (BYTE_W),
    .IDX_W     (IDX_W),
    .INSTR_W   (INSTR_W),
    .IMM_W     (IMM_W),
    .PAIR_BASE (PAIR_BASE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .instr    (instr),
    .flagsIn  (flagsIn),
    .rdLo     (regRdLo),
    .rdHi     (regRdHi),
    .rdIdx    (regRdIdx),
    .wrIdx    (regWrIdx),
    .wrLo     (regWrLo),
    .wrHi     (regWrHi),
    .flagsOut (flagsOut)
  );

  assign regWrEn   = strobes.writeBack;
  assign flagsWrEn = strobes.writeBack;

endmodule

// File: tb/pair_imm_adder_tb_top.sv
module pair_imm_adder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  statusReg = '0;
  logic [7:0]  regRdLo, regRdHi;
  logic [4:0]  regRdIdx, regWrIdx;
  logic        regWrEn, flagsWrEn, busy;
  logic [7:0]  regWrLo, regWrHi, flagsOut;
  logic [7:0]  regFile [32];

  int checkCount = 0;
  int failCount  = 0;
  int cycleCnt   = 0;
  int writeCount = 0;

  typedef struct {
    logic [4:0] idx;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] flags;
    int         cyc;
  } expItem_t;

  expItem_t expQ [$];

  always #5 clk = ~clk;

  pair_imm_adder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .flagsIn(statusReg),
    .regRdLo(regRdLo), .regRdHi(regRdHi), .regRdIdx(regRdIdx),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrLo(regWrLo), .regWrHi(regWrHi),
    .flagsWrEn(flagsWrEn), .flagsOut(flagsOut), .busy(busy)
  );

  // register file harness
  assign regRdLo = regFile[regRdIdx];
  assign regRdHi = regFile[regRdIdx + 5'd1];

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (regWrEn) begin
      regFile[regWrIdx]        <= regWrLo;
      regFile[regWrIdx + 5'd1] <= regWrHi;
    end
    if (flagsWrEn) statusReg <= flagsOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  // monitor: compares each write cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      writeCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected write", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(cycleCnt == e.cyc + 1, "R2", "write cycle", cycleCnt, e.cyc + 1);
        check(flagsWrEn, "R2", "flags strobe", int'(flagsWrEn), 1);
        check(regWrIdx == e.idx, "R3", "write index", regWrIdx, e.idx);
        check({regWrHi, regWrLo} == {e.hi, e.lo}, "R5", "result word",
              {regWrHi, regWrLo}, {e.hi, e.lo});
        check(flagsOut[0] == e.flags[0] && flagsOut[3] == e.flags[3], "R6/R7 carry-overflow",
              "flags C,V", flagsOut, e.flags);
        check(flagsOut[2:1] == e.flags[2:1], "R8", "flags Z,N", flagsOut, e.flags);
        check(flagsOut[4] == e.flags[4], "R9", "flag S", flagsOut, e.flags);
        check(flagsOut[7:5] == e.flags[7:5], "R10", "flags H,T,I", flagsOut, e.flags);
      end
    end
  end

  function automatic logic [15:0] encode(input bit sub, input int pair, input int imm);
    logic [5:0] i6;
    logic [1:0] p2;
    i6 = 6'(imm);
    p2 = 2'(pair);
    return {7'b1001011, sub, i6[5:4], p2, i6[3:0]};
  endfunction

  task automatic preload(input int pair, input logic [15:0] val, input logic [7:0] st);
    regFile[24 + 2 * pair]     = val[7:0];
    regFile[24 + 2 * pair + 1] = val[15:8];
    statusReg = st;
  endtask

  function automatic expItem_t predict(input logic [15:0] ins);
    expItem_t   e;
    int         lowIdx;
    logic [15:0] orig, res, imm;
    logic        c, v, n;
    lowIdx = 24 + 2 * int'(ins[5:4]);
    imm    = {10'd0, ins[7:6], ins[3:0]};
    orig   = {regFile[lowIdx + 1], regFile[lowIdx]};
    res    = ins[8] ? orig - imm : orig + imm;
    n      = res[15];
    if (ins[8]) begin c = res[15] & ~orig[15]; v = orig[15] & ~res[15]; end
    else        begin c = orig[15] & ~res[15]; v = res[15] & ~orig[15]; end
    e.idx   = 5'(lowIdx);
    e.lo    = res[7:0];
    e.hi    = res[15:8];
    e.flags = {statusReg[7:5], n ^ v, v, n, (res == 16'd0), c};
    e.cyc   = 0;
    return e;
  endfunction

  // driver: launch one operation; optional second start while busy
  task automatic runOp(input logic [15:0] ins, input bit extra, input logic [15:0] ins2);
    expItem_t e;
    int       wcBefore;
    wcBefore = writeCount;
    e = predict(ins);
    @(negedge clk);
    start = 1'b1;
    instr = ins;
    @(negedge clk);
    start = 1'b0;
    e.cyc = cycleCnt;
    expQ.push_back(e);
    check(busy, "R2", "busy in read cycle", int'(busy), 1);
    check(!regWrEn, "R2", "no write in read cycle", int'(regWrEn), 0);
    if (extra) begin
      start = 1'b1;
      instr = ins2;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(!regWrEn && !flagsWrEn, "R2", "strobes low when idle", int'(regWrEn), 0);
    check(writeCount == wcBefore + 1, extra ? "R11" : "R2", "write count",
          writeCount - wcBefore, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regFile[i] = 8'(i * 7);
    repeat (3) @(negedge clk);
    check(!busy && !regWrEn && !flagsWrEn, "R1", "reset state",
          {busy, regWrEn, flagsWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !regWrEn, "R1", "idle after reset", {busy, regWrEn}, 0);

    // R5 plain add, pair 0, low immediate field only
    preload(0, 16'h1234, 8'h1F);
    runOp(encode(0, 0, 5), 0, '0);
    // R6 carry out and zero result
    preload(0, 16'hFFFF, 8'hE0);
    runOp(encode(0, 0, 1), 0, '0);
    // R6 signed overflow, immediate at maximum (R4)
    preload(1, 16'h7FFF, 8'h40);
    runOp(encode(0, 1, 63), 0, '0);
    // R7 borrow out of zero
    preload(2, 16'h0000, 8'hA0);
    runOp(encode(1, 2, 1), 0, '0);
    // R7 signed wrap from most negative value
    preload(3, 16'h8000, 8'h00);
    runOp(encode(1, 3, 1), 0, '0);
    // R8 exact cancellation, high immediate field only (R4)
    preload(1, 16'h0030, 8'h1F);
    runOp(encode(1, 1, 6'h30), 0, '0);
    // R4 low field only on a different pair
    preload(2, 16'h0100, 8'hC0);
    runOp(encode(0, 2, 6'h03), 0, '0);
    // zero immediate keeps the value
    preload(3, 16'hBEEF, 8'h20);
    runOp(encode(0, 3, 0), 0, '0);
    // add wrapping to zero from 0xFFC1
    preload(0, 16'hFFC1, 8'h00);
    runOp(encode(0, 0, 63), 0, '0);
    // subtract crossing negative to positive
    preload(2, 16'h8010, 8'h60);
    runOp(encode(1, 2, 6'h20), 0, '0);

    // R11 second start in read cycle aimed at pair 3 must be ignored
    preload(0, 16'h0400, 8'h80);
    preload(3, 16'h5A5A, 8'h80);
    runOp(encode(0, 0, 6'h11), 1, encode(1, 3, 6'h3F));
    check({regFile[31], regFile[30]} == 16'h5A5A, "R11", "other pair untouched",
          {regFile[31], regFile[30]}, 16'h5A5A);

    check(expQ.size() == 0, "R2", "scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule